// File: doc/BRIEF.md
# DMA Event Interrupt Register Block

This block gathers completion events from a DMA engine that has two groups of channels: up to four normal channels and up to four dedicated channels. Each channel raises two one-cycle event pulses. One marks the halfway point of a transfer and the other marks the end of it. The block holds two registers. The first is an enable register with one bit per event. The second is a pending register that latches each enabled event. The block drives one interrupt line, which is high while any pending and enabled event remains.

Software reaches the two registers through a simple word port: a write strobe, an address, write data and combinational read data. The enable register sits at offset 0 and the pending register at offset 4. A write to the pending register clears every bit written as 1. Any other offset reads as zero and takes no effect from writes. The address decoder picks one of three selections: enable (offset 0), status (offset 4) or none (any other offset). The block has no sequencing state beyond the two registers.

Top module: `dma_irq_regs`

## Requirements
- R1: After reset, and at once while the asynchronous active-low reset is held, the enable register and the pending register are zero and `irq` is low.
- R2: A write at offset 0 stores the written data into the enable register, masked to the defined event bits, and the new value reads back at offset 0 from the next cycle on.
- R3: Normal channel n (0..3) owns bit 2n for its halfway event and bit 2n+1 for its end event, in both registers.
- R4: Dedicated channel m (0..3) owns bit 16+2m for its halfway event and bit 17+2m for its end event, in both registers.
- R5: A pending bit is set on the clock edge after its event pulse only if the matching enable bit was 1 during the pulse. A disabled event leaves the pending bit unchanged.
- R6: A write at offset 4 clears each pending bit written as 1 on the next edge, and leaves each pending bit written as 0 unchanged.
- R7: Writing 0x00FF00FF at offset 4 clears every pending bit.
- R8: `irq` is high exactly when some bit is both pending and enabled. Clearing an enable bit lowers `irq` without clearing the pending bit.
- R9: When an enabled event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R10: Bits 8..15 and 24..31 of both registers always read as zero, and writes to them are ignored.
- R11: A write to any offset other than 0 or 4 changes no register, and a read there returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Byte offset of the register being accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| norm_half | input | 4 | Halfway event pulses, one per normal channel |
| norm_done | input | 4 | End event pulses, one per normal channel |
| ded_half | input | 4 | Halfway event pulses, one per dedicated channel |
| ded_done | input | 4 | End event pulses, one per dedicated channel |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the collision in R9: a clearing write and an enabled event must land on the same pending bit at the same clock edge. The stimulus table includes a row that drives both the write strobe and the event pulse in one cycle. Two other states also take several rows to build up: a pending bit whose enable has since been removed, which keeps `irq` low, and a mix of set bits in both halves of the word. The table reaches both before it exercises the selective clear and the full clear.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int REG_W    = 32;
    localparam int DED_BASE = 16;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_NONE   = 2'd2
    } reg_sel_e;

    // Mask of bits that belong to a defined channel event
    function automatic logic [REG_W-1:0] field_mask(input int n_norm, input int n_ded);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (i < 2 * n_norm)
                m[i] = 1'b1;
            if ((i >= DED_BASE) && (i < DED_BASE + 2 * n_ded))
                m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dma_irq_evmap.sv
module dma_irq_evmap
    import dma_irq_pkg::*;
#(
    parameter int NUM_NORM = 4,
    parameter int NUM_DED  = 4
) (
    input  logic [NUM_NORM-1:0] norm_half,
    input  logic [NUM_NORM-1:0] norm_done,
    input  logic [NUM_DED-1:0]  ded_half,
    input  logic [NUM_DED-1:0]  ded_done,
    output logic [REG_W-1:0]    ev_vec
);

    logic [REG_W-1:0] norm_part;
    logic [REG_W-1:0] ded_part;

    always_comb begin
        norm_part = '0;
        ded_part  = '0;
        for (int n = 0; n < NUM_NORM; n++) begin
            norm_part[2*n]     = norm_half[n];
            norm_part[2*n + 1] = norm_done[n];
        end
        for (int m = 0; m < NUM_DED; m++) begin
            ded_part[DED_BASE + 2*m]     = ded_half[m];
            ded_part[DED_BASE + 2*m + 1] = ded_done[m];
        end
    end

    assign ev_vec = norm_part | ded_part;

endmodule

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
    import dma_irq_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int ENA_OFF = 0,
    parameter int STA_OFF = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    localparam logic [ADDR_W-1:0] ENA_A = ADDR_W'(ENA_OFF);
    localparam logic [ADDR_W-1:0] STA_A = ADDR_W'(STA_OFF);

    always_comb begin
        if (addr == ENA_A)
            sel = SEL_ENABLE;
        else if (addr == STA_A)
            sel = SEL_STATUS;
        else
            sel = SEL_NONE;
    end

endmodule

// File: rtl/dma_irq_pending.sv
module dma_irq_pending
    import dma_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_vec,
    input  logic [REG_W-1:0] clr_vec,
    output logic [REG_W-1:0] pend
);

    genvar b;
    generate
        for (b = 0; b < REG_W; b++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    pend[b] <= 1'b0;
                else if (set_vec[b])
                    pend[b] <= 1'b1;
                else if (clr_vec[b])
                    pend[b] <= 1'b0;
            end

            AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                set_vec[b] |=> pend[b]); // R9
            AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_vec[b] && !set_vec[b]) |=> !pend[b]); // R6
            AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
                (!pend[b] && !set_vec[b]) |=> !pend[b]); // R5
            AST_KEEP_SET: assert property (@(posedge clk) disable iff (!rst_n)
                (pend[b] && !clr_vec[b]) |=> pend[b]); // R6
        end
    endgenerate

endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
    import dma_irq_pkg::*;
#(
    parameter int NUM_NORM = 4,
    parameter int NUM_DED  = 4,
    parameter int ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [NUM_NORM-1:0] norm_half,
    input  logic [NUM_NORM-1:0] norm_done,
    input  logic [NUM_DED-1:0]  ded_half,
    input  logic [NUM_DED-1:0]  ded_done,
    output logic                irq
);

    localparam logic [REG_W-1:0] FIELD_MASK = field_mask(NUM_NORM, NUM_DED);

    reg_sel_e         sel;
    logic [REG_W-1:0] ev_vec;
    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] pend;
    logic             wr_en;
    logic             wr_sta;

    dma_irq_decode #(
        .ADDR_W  (ADDR_W),
        .ENA_OFF (0),
        .STA_OFF (4)
    ) u_decode (
        .addr (reg_addr),
        .sel  (sel)
    );

    dma_irq_evmap #(
        .NUM_NORM (NUM_NORM),
        .NUM_DED  (NUM_DED)
    ) u_evmap (
        .norm_half (norm_half),
        .norm_done (norm_done),
        .ded_half  (ded_half),
        .ded_done  (ded_done),
        .ev_vec    (ev_vec)
    );

    assign wr_en  = reg_wr && (sel == SEL_ENABLE);
    assign wr_sta = reg_wr && (sel == SEL_STATUS);

    // Enable register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_en)
            en_q <= reg_wdata & FIELD_MASK;
    end

    assign set_vec = ev_vec & en_q;
    assign clr_vec = wr_sta ? (reg_wdata & FIELD_MASK) : '0;

    dma_irq_pending u_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .pend    (pend)
    );

    // Read mux and interrupt output
    always_comb begin
        unique case (sel)
            SEL_ENABLE: reg_rdata = en_q;
            SEL_STATUS: reg_rdata = pend;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq = |(pend & en_q);

    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en_q == ($past(reg_wdata) & FIELD_MASK))); // R2
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_q)); // R11
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~FIELD_MASK) == '0); // R10
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(|ev_vec) || $past(reg_wr))); // R8

endmodule

// File: tb/dma_irq_regs_tb.sv
module dma_irq_regs_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    typedef struct packed {
        logic [31:0] tag;
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] wdata;
        logic [15:0] ev;       // [3:0] norm_half [7:4] norm_done [11:8] ded_half [15:12] ded_done
        logic [31:0] exp_en;
        logic [31:0] exp_pend;
        logic        exp_irq;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{"R2",  1'b1, 4'h0, 32'hFFFF_FFFF, 16'h0000, 32'h00FF_00FF, 32'h0000_0000, 1'b0},
        '{"R3",  1'b0, 4'h0, 32'h0,         16'h0001, 32'h00FF_00FF, 32'h0000_0001, 1'b1},
        '{"R3",  1'b0, 4'h0, 32'h0,         16'h0080, 32'h00FF_00FF, 32'h0000_0081, 1'b1},
        '{"R4",  1'b0, 4'h0, 32'h0,         16'h0400, 32'h00FF_00FF, 32'h0010_0081, 1'b1},
        '{"R4",  1'b0, 4'h0, 32'h0,         16'h8000, 32'h00FF_00FF, 32'h0090_0081, 1'b1},
        '{"R6",  1'b1, 4'h4, 32'h0000_0080, 16'h0000, 32'h00FF_00FF, 32'h0090_0001, 1'b1},
        '{"R8",  1'b1, 4'h0, 32'h0000_0002, 16'h0000, 32'h0000_0002, 32'h0090_0001, 1'b0},
        '{"R5",  1'b0, 4'h0, 32'h0,         16'h0011, 32'h0000_0002, 32'h0090_0003, 1'b1},
        '{"R7",  1'b1, 4'h4, 32'h00FF_00FF, 16'h0000, 32'h0000_0002, 32'h0000_0000, 1'b0},
        '{"R9",  1'b1, 4'h4, 32'h0000_0002, 16'h0010, 32'h0000_0002, 32'h0000_0002, 1'b1},
        '{"R11", 1'b1, 4'h8, 32'hFFFF_FFFF, 16'h0000, 32'h0000_0002, 32'h0000_0002, 1'b1},
        '{"R6",  1'b1, 4'h4, 32'hFFFF_0000, 16'h0000, 32'h0000_0002, 32'h0000_0002, 1'b1},
        '{"R10", 1'b1, 4'h4, 32'hFFFF_FFFF, 16'h0000, 32'h0000_0002, 32'h0000_0000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  norm_half = '0;
    logic [3:0]  norm_done = '0;
    logic [3:0]  ded_half = '0;
    logic [3:0]  ded_done = '0;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_regs u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .norm_half (norm_half),
        .norm_done (norm_done),
        .ded_half  (ded_half),
        .ded_done  (ded_done),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic wr, input logic [3:0] addr,
                         input logic [31:0] wdata, input logic [15:0] ev);
        @(negedge clk);
        reg_wr    = wr;
        reg_addr  = addr;
        reg_wdata = wdata;
        norm_half = ev[3:0];
        norm_done = ev[7:4];
        ded_half  = ev[11:8];
        ded_done  = ev[15:12];
        @(posedge clk);
        #1;
        reg_wr    = 1'b0;
        norm_half = '0;
        norm_done = '0;
        ded_half  = '0;
        ded_done  = '0;
    endtask

    task automatic check_state(input string req, input logic [31:0] e_en,
                               input logic [31:0] e_pend, input logic e_irq);
        reg_addr = 4'h0;
        #1;
        check({req, " enable"}, reg_rdata, e_en);
        reg_addr = 4'h4;
        #1;
        check({req, " pending"}, reg_rdata, e_pend);
        check({req, " irq"}, {31'b0, irq}, {31'b0, e_irq});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: state while and after reset
        #(CLK_PERIOD * 3);
        check_state("R1 in reset", 32'h0, 32'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_state("R1", 32'h0, 32'h0, 1'b0);
        reg_addr = 4'h8;
        #1;
        check("R11 read unmapped", reg_rdata, 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].wr, VEC[i].addr, VEC[i].wdata, VEC[i].ev);
            check_state(string'(VEC[i].tag), VEC[i].exp_en, VEC[i].exp_pend, VEC[i].exp_irq);
        end

        // R5: disabled dedicated event does not latch (enable is 0x2 here)
        apply(1'b0, 4'h0, 32'h0, 16'h0100);
        check_state("R5 dedicated disabled", 32'h2, 32'h0, 1'b0);

        // R4: dedicated channel 0 end event maps to bit 17
        apply(1'b1, 4'h0, 32'h0002_0000, 16'h0000);
        apply(1'b0, 4'h0, 32'h0, 16'h1000);
        check_state("R4 ded0 done", 32'h0002_0000, 32'h0002_0000, 1'b1);

        // R3: normal channel 1 end event maps to bit 3
        apply(1'b1, 4'h0, 32'h0000_0008, 16'h0000);
        check_state("R8 enable removed", 32'h8, 32'h0002_0000, 1'b0);
        apply(1'b0, 4'h0, 32'h0, 16'h0020);
        check_state("R3 norm1 done", 32'h8, 32'h0002_0008, 1'b1);

        // R1: asynchronous reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_state("R1 mid-run reset", 32'h0, 32'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_state("R1 after release", 32'h0, 32'h0, 1'b0);

        finish_run();
    end

endmodule